// File: doc/BRIEF.md
# Coded-Address Constant Multiplier with Odd-Multiple Table

This block multiplies a 5-bit unsigned input word by a constant coefficient fixed at elaboration. It does not keep all 32 products. It folds the input onto a 4-bit coded address and a direction bit. The product is then formed as sixteen times the coefficient, plus or minus the coded magnitude. Inputs with the top bit set add, and inputs with the top bit clear subtract.

The coded magnitude is the coefficient times the coded address. It is not read from a full table. The address is split into an odd part and a count of trailing zeros. The odd part selects one of eight stored odd multiples, and a barrel shifter of at most three positions restores the even multiples. A coded address of zero does not use a table entry; the table output is forced to zero. The all-zero input cannot be coded in four bits, so its product is forced to zero.

The table is built from the coefficient parameter when the design elaborates. A caller presents a word with a strobe and gets the registered product one clock later.

Top module: `aoms_lut_mult`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_prod` is 0.
- R2: `out_valid` is 1 in the cycle after a rising clock edge that samples `in_valid` high, and 0 after an edge that samples it low.
- R3: For an input with bit 4 set (16..31), `out_prod` equals COEF × `in_x`. This value is formed as 16·COEF plus COEF times the low four bits.
- R4: For an input from 1 to 15, `out_prod` equals COEF × `in_x`. This value is formed as 16·COEF minus COEF times the 4-bit two's complement of the low four bits.
- R5: The input 16 gives a coded address of zero. The table output is forced to zero, so `out_prod` equals 16·COEF.
- R6: The input 0 gives `out_prod` = 0.
- R7: Coded addresses with trailing zeros are rebuilt from an odd entry shifted left by the number of trailing zeros. The shift is at most 3, as for inputs 8 and 24 (address 8 = 1 << 3). These addresses give the exact product.
- R8: After an edge that samples `in_valid` low, `out_prod` keeps its value whatever `in_x` carries.
- R9: With COEF at its largest value 2^COEF_W − 1 and input 31, the product fits in COEF_W+5 bits without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: `in_x` holds a word to multiply |
| in_x | input | 5 | Unsigned multiplicand |
| out_valid | output | 1 | Product register was loaded on the last edge |
| out_prod | output | COEF_W+5 | COEF × multiplicand, registered |

## Verification
The hardest cases to reach are the paths that avoid the odd-multiple table. These are the zeroed table output for input 16, the forced zero for input 0, and the three-position shift for inputs 8 and 24. They must be hit for several coefficients, including the all-ones and smallest nonzero values where carries and empty products show up. The stimulus runs every input word in order and again in a scrambled order with idle gaps. It drives four instances with different coefficients and widths from the same words. A scoreboard of expected products is compared against each instance. During idle gaps the input carries junk, so the hold behaviour is checked too.

// File: rtl/aoms_pkg.sv
package aoms_pkg;
   localparam int unsigned X_W   = 5;
   localparam int unsigned ADR_W = X_W - 1;
   localparam int unsigned IDX_W = ADR_W - 1;
   localparam int unsigned SH_W  = 2;
   localparam int unsigned N_ODD = 1 << IDX_W;

   typedef struct packed {
      logic              neg;     // subtract coded magnitude from 16*COEF
      logic              zero;    // coded address is zero: table output cleared
      logic              force0;  // input word zero: product cleared
      logic [ADR_W-1:0]  addr;
      logic [IDX_W-1:0]  idx;
      logic [SH_W-1:0]   sh;
   } code_t;
endpackage

// File: rtl/aoms_coder.sv
module aoms_coder
   import aoms_pkg::*;
(
   input  logic [X_W-1:0] x,
   output code_t          code
);
   logic [ADR_W-1:0] adr;
   logic [ADR_W-1:0] odd;
   logic [SH_W-1:0]  tz;

   always_comb begin
      adr = x[X_W-1] ? x[ADR_W-1:0] : (~x[ADR_W-1:0] + ADR_W'(1));
      if (adr[0])      tz = 2'd0;
      else if (adr[1]) tz = 2'd1;
      else if (adr[2]) tz = 2'd2;
      else             tz = 2'd3;
      odd = adr >> tz;
      code.neg    = ~x[X_W-1];
      code.zero   = (adr == '0);
      code.force0 = (x == '0);
      code.addr   = adr;
      code.idx    = odd[ADR_W-1:1];
      code.sh     = tz;
   end
endmodule

// File: rtl/aoms_odd_table.sv
module aoms_odd_table
   import aoms_pkg::*;
#(
   parameter int unsigned COEF_W = 8,
   parameter int unsigned COEF   = 173,
   localparam int unsigned MAG_W = COEF_W + ADR_W
)(
   input  logic [IDX_W-1:0] idx,
   input  logic             clear,
   output logic [MAG_W-1:0] odd_mult
);
   logic [MAG_W-1:0] entry [N_ODD];

   for (genvar i = 0; i < N_ODD; i++) begin : g_entry
      assign entry[i] = MAG_W'(COEF * (2 * i + 1));
   end

   assign odd_mult = clear ? '0 : entry[idx];
endmodule

// File: rtl/aoms_shifter.sv
module aoms_shifter
   import aoms_pkg::*;
#(
   parameter int unsigned W = 12
)(
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] sh,
   output logic [W-1:0]    dout
);
   logic [W-1:0] stage [SH_W+1];

   assign stage[0] = din;
   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      assign stage[s+1] = sh[s] ? (stage[s] << (1 << s)) : stage[s];
   end
   assign dout = stage[SH_W];
endmodule

// File: rtl/aoms_lut_mult.sv
module aoms_lut_mult
   import aoms_pkg::*;
#(
   parameter int unsigned COEF_W = 8,
   parameter int unsigned COEF   = 173,
   localparam int unsigned MAG_W  = COEF_W + ADR_W,
   localparam int unsigned PROD_W = COEF_W + X_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [X_W-1:0]    in_x,
   output logic              out_valid,
   output logic [PROD_W-1:0] out_prod
);
   if (COEF_W < 1 || COEF_W > 24) begin : g_bad_width
      $error("COEF_W must lie in 1..24");
   end
   if (COEF > (1 << COEF_W) - 1) begin : g_bad_coef
      $error("COEF does not fit in COEF_W bits");
   end

   localparam logic [PROD_W-1:0] BASE   = PROD_W'(COEF) << ADR_W;
   localparam logic [MAG_W-1:0]  COEF_M = MAG_W'(COEF);

   code_t             code;
   logic [MAG_W-1:0]  odd_mult;
   logic [MAG_W-1:0]  mag;
   logic [PROD_W-1:0] mag_ext;
   logic [PROD_W-1:0] prod_nxt;

   aoms_coder u_coder (.x(in_x), .code(code));

   aoms_odd_table #(.COEF_W(COEF_W), .COEF(COEF)) u_table (
      .idx(code.idx), .clear(code.zero), .odd_mult(odd_mult)
   );

   aoms_shifter #(.W(MAG_W)) u_shift (.din(odd_mult), .sh(code.sh), .dout(mag));

   assign mag_ext = PROD_W'(mag);

   always_comb begin
      if (code.force0)   prod_nxt = '0;
      else if (code.neg) prod_nxt = BASE - mag_ext;
      else               prod_nxt = BASE + mag_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_prod  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_prod <= prod_nxt;
      end
   end

   // R2: strobe reaches the flag one edge later, and only then
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R8: idle cycles leave the product alone
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_prod));
   // R6: zero word gives zero product
   a_r6_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_x == '0) |=> out_prod == '0);
   // R5: zero coded address clears the table output
   a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      code.zero |-> mag == '0);
   // R7: odd index and shift count rebuild the coded address
   a_r7_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
      !code.zero |-> (({code.idx, 1'b1}) << code.sh) == code.addr);
   // R3/R4: shifted odd multiple is COEF times the coded address
   a_r4_mag: assert property (@(posedge clk) disable iff (!rst_n)
      mag == COEF_M * MAG_W'(code.addr));
endmodule

// File: tb/tb_aoms_lut_mult.sv
module tb_aoms_lut_mult;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [4:0] in_x = 5'd0;

   logic        v0, v1, v2, v3;
   logic [12:0] p0, p1, p2;
   logic [16:0] p3;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int q[$];
   longint last [4];

   localparam longint CF [4] = '{173, 255, 1, 4093};

   always #2 clk = ~clk;

   aoms_lut_mult #(.COEF_W(8),  .COEF(173))  dut      (.clk, .rst_n, .in_valid, .in_x, .out_valid(v0), .out_prod(p0));
   aoms_lut_mult #(.COEF_W(8),  .COEF(255))  dut_max  (.clk, .rst_n, .in_valid, .in_x, .out_valid(v1), .out_prod(p1));
   aoms_lut_mult #(.COEF_W(8),  .COEF(1))    dut_one  (.clk, .rst_n, .in_valid, .in_x, .out_valid(v2), .out_prod(p2));
   aoms_lut_mult #(.COEF_W(12), .COEF(4093)) dut_wide (.clk, .rst_n, .in_valid, .in_x, .out_valid(v3), .out_prod(p3));

   task automatic chk(string req, int n, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s inst%0d: actual %0d expected %0d", req, n, act, exp);
      end
   endtask

   function automatic string req_of(int x, int n);
      if (x == 0)                 return "R6";
      if (x == 16)                return "R5";
      if (x == 8 || x == 24)      return "R7";
      if (n == 1 && x == 31)      return "R9";
      if (x >= 16)                return "R3";
      return "R4";
   endfunction

   function automatic longint prod_of(int n);
      case (n)
         0: return longint'(p0);
         1: return longint'(p1);
         2: return longint'(p2);
         default: return longint'(p3);
      endcase
   endfunction

   function automatic bit valid_of(int n);
      case (n)
         0: return v0;
         1: return v1;
         2: return v2;
         default: return v3;
      endcase
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic drive(int x);
      @(negedge clk);
      in_valid = 1'b1;
      in_x     = 5'(x);
      q.push_back(x);
   endtask

   task automatic idle(int junk);
      @(negedge clk);
      in_valid = 1'b0;
      in_x     = 5'(junk);
   endtask

   // scoreboard monitor: sampled just after each rising edge
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         bit exp_v;
         int x;
         exp_v = (q.size() != 0);
         x = exp_v ? q.pop_front() : 0;
         for (int n = 0; n < 4; n++) begin
            chk("R2", n, longint'(valid_of(n)), longint'(exp_v));
            if (exp_v) begin
               chk(req_of(x, n), n, prod_of(n), CF[n] * x);
               last[n] = prod_of(n);
            end else begin
               chk("R8", n, prod_of(n), last[n]);
            end
         end
      end
   end

   initial begin
      int x;
      for (int n = 0; n < 4; n++) last[n] = 0;
      repeat (3) @(negedge clk);
      for (int n = 0; n < 4; n++) begin
         chk("R1", n, longint'(valid_of(n)), 0);
         chk("R1", n, prod_of(n), 0);
      end
      rst_n = 1'b1;
      idle(0);
      // every word, in order, back to back
      for (int k = 0; k < 32; k++) drive(k);
      idle(31);
      idle(17);
      // scrambled order with gaps carrying junk on in_x
      x = 5;
      for (int k = 0; k < 32; k++) begin
         x = (x * 13 + 7) % 32;
         drive(x);
         if (k % 3 == 2) begin
            idle(31 - x);
            idle(x ^ 21);
         end
      end
      // corner words again, separated
      foreach (CF[i]) begin
         drive(0);  idle(16);
         drive(16); idle(0);
         drive(8);  drive(24); idle(31);
         drive(31); idle(1);
      end
      repeat (3) idle(9);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R2 watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end
endmodule